// File: doc/BRIEF.md
# Periodic Impedance Calibration Controller

This controller keeps a binary-weighted output-driver strength code close to its optimum while supply voltage and temperature drift. A free-running cycle counter restarts each time it expires, and every expiry is one evaluation. At an evaluation the controller samples two comparator flags. One flag says the driver is too strong and the other says it is too weak. The controller then moves the code by at most one step toward the optimum.

The optimum impedance is one fifth of an external reference resistor, and that resistor must lie between 175 and 350 ohms. The analog legs, the resistor and the comparator are outside this block. The block only turns the comparator decision into a code. It gives a one-cycle strobe for each evaluation and a separate one-cycle pulse for each code change. A clear enable input pauses calibration and restarts the interval when it is raised again.

Top module: `imp_cal_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, `code` equals midscale (only the MSB set, 4 for a 3-bit code) and `eval_stb` and `code_chg` are 0.
- R2: While `en` is high, an evaluation happens every INTERVAL cycles. The first comes INTERVAL rising edges after `en` is seen high. `eval_stb` is high for exactly the one cycle that follows each evaluation edge.
- R3: At an evaluation where `cmp_weak`=1 and `cmp_strong`=0, `code` increases by exactly one (a higher code is a stronger driver), unless it is already all-ones.
- R4: At an evaluation where `cmp_strong`=1 and `cmp_weak`=0, `code` decreases by exactly one, unless it is already all-zeros.
- R5: The code saturates. An increase at all-ones and a decrease at all-zeros leave it unchanged, and it never wraps.
- R6: At an evaluation where both flags or neither flag is asserted, `code` holds its value.
- R7: While `en` is low, no evaluation happens, `code` holds, and the interval counter is cleared.
- R8: `code_chg` is high for one cycle, in the same cycle as `eval_stb`, exactly when the evaluation changed `code`. Outside evaluations `code` never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Calibration enable; low pauses and clears the interval |
| cmp_strong | input | 1 | Comparator: driver too strong |
| cmp_weak | input | 1 | Comparator: driver too weak |
| code | output | CODE_W | Binary-weighted driver strength code |
| eval_stb | output | 1 | One-cycle pulse after each evaluation |
| code_chg | output | 1 | One-cycle pulse when an evaluation changed the code |

## Verification
Saturation and evaluation can land in the same cycle. So can an enable drop and counter expiry. The bench drives the code against each rail with long runs of a single comparator flag, and it toggles `en` at random points, some of them just before expiry. A bench reference model, built from the requirements, predicts `code`, `eval_stb` and `code_chg` every cycle. An expected strobe without a step shows saturation. A suppressed strobe shows the enable taking effect.

// File: rtl/imp_cal_ctrl.sv
module imp_cal_ctrl #(
  parameter int CODE_W   = 6,
  parameter int INTERVAL = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cmp_strong,
  input  logic              cmp_weak,
  output logic [CODE_W-1:0] code,
  output logic              eval_stb,
  output logic              code_chg
);

  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0]  LAST = CNT_W'(INTERVAL - 1);
  localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] TOP  = '1;

  logic [CNT_W-1:0] cnt;

  wire tick = en && (cnt == LAST);
  wire up   = cmp_weak && !cmp_strong && (code != TOP);
  wire dn   = cmp_strong && !cmp_weak && (code != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      code     <= MID;
      eval_stb <= 1'b0;
      code_chg <= 1'b0;
    end else begin
      cnt      <= (!en || tick) ? '0 : cnt + 1'b1;
      eval_stb <= tick;
      code_chg <= tick && (up || dn);
      if (tick && up)      code <= code + 1'b1;
      else if (tick && dn) code <= code - 1'b1;
    end
  end

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, code} == {1'b0, $past(code)}) ||
    ({1'b0, code} == {1'b0, $past(code)} + 1'b1) ||
    ({1'b0, code} + 1'b1 == {1'b0, $past(code)})); // R3

  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code) == TOP) |-> (code != '0)); // R5

  AST_NO_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code) == '0) |-> (code != TOP)); // R5

  AST_MOVE_ON_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (code != $past(code)) |-> eval_stb); // R8

  AST_CHG_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
    code_chg |-> eval_stb); // R8

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eval_stb |=> !eval_stb); // R2

  AST_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !eval_stb); // R7

endmodule

// File: tb/test_imp_cal_ctrl.sv
module test_imp_cal_ctrl;
  localparam int CW  = 3;
  localparam int IVL = 8;
  localparam logic [CW-1:0] MID = 3'd4;
  localparam logic [CW-1:0] TOP = 3'd7;

  logic clk = 0, rst_n = 0, en = 0, cmp_strong = 0, cmp_weak = 0;
  logic [CW-1:0] code;
  logic eval_stb, code_chg;

  int n_cmp = 0, n_bad = 0;
  int m_cnt;
  logic [CW-1:0] m_code;
  logic m_stb, m_chg;
  string tag_code, tag_stb;

  imp_cal_ctrl #(.CODE_W(CW), .INTERVAL(IVL)) i_imp_cal_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .cmp_strong(cmp_strong),
    .cmp_weak(cmp_weak), .code(code), .eval_stb(eval_stb), .code_chg(code_chg));

  always #2 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic tick, up, dn;
    tick = en && (m_cnt == IVL - 1);
    up   = cmp_weak && !cmp_strong && (m_code != TOP);
    dn   = cmp_strong && !cmp_weak && (m_code != 0);
    tag_stb = en ? "R2" : "R7";
    if (!tick)                                       tag_code = en ? "R8" : "R7";
    else if (cmp_weak == cmp_strong)                 tag_code = "R6";
    else if (cmp_weak && m_code == TOP)              tag_code = "R5";
    else if (cmp_strong && m_code == 0)              tag_code = "R5";
    else                                             tag_code = cmp_weak ? "R3" : "R4";
    m_stb = tick;
    m_chg = tick && (up || dn);
    if (tick && up)      m_code = m_code + 1'b1;
    else if (tick && dn) m_code = m_code - 1'b1;
    m_cnt = (!en || tick) ? 0 : m_cnt + 1;
  endtask

  task automatic drive(int mode);
    logic [31:0] r;
    r = $urandom;
    case (mode)
      1: begin cmp_weak = 1; cmp_strong = 0; end
      2: begin cmp_weak = 0; cmp_strong = 1; end
      3: begin cmp_weak = 1; cmp_strong = 1; end
      4: begin cmp_weak = 0; cmp_strong = 0; end
      default: begin cmp_weak = r[0]; cmp_strong = r[1]; end
    endcase
    if (mode == 5) en = (r[5:2] != 0);
    else if (mode == 6) en = 0;
    else en = 1;
  endtask

  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag_code, code, m_code);
      chk(tag_stb, eval_stb, m_stb);
      chk("R8", code_chg, m_chg);
      drive(mode);
      model_step();
    end
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", code, MID);
    chk("R1", eval_stb, 0);
    chk("R1", code_chg, 0);
    m_code = MID; m_cnt = 0; m_stb = 0; m_chg = 0;
    tag_code = "R1"; tag_stb = "R1";
    drive(1);
    rst_n = 1;
    model_step();
    run(IVL * 6, 1);
    chk("R5", code, TOP);
    run(IVL * 3, 3);
    run(IVL * 10, 2);
    chk("R5", code, 0);
    run(IVL * 2, 4);
    run(IVL * 3, 1);
    run(IVL - 3, 6);
    run(IVL * 3, 5);
    run(IVL * 200, 0);
    run(IVL * 200, 5);
    @(negedge clk);
    chk("R8", code, m_code);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule